// File: doc/BRIEF.md
# Light-Load Pulse-Skip Mode Controller

This block decides when a constant on-time buck controller may skip pulses at light load. Once per switching period it receives a strobe and a flag saying whether the inductor-current zero-crossing comparator tripped during the low-side conduction interval. When the flag has been seen on a run of consecutive periods, the controller enters power-save mode. In that mode it asks the low-side driver logic to release the switch at the zero crossing and selects the stretched (one and a half times) on-time. A single period without a crossing drops it straight back to normal operation.

A two-bit enable code, decoded from a three-level input pin by logic outside this block, picks between off, on with power-save allowed, and on with forced continuous conduction. When the code means off, the block requests that both gate drivers float. A fault input, or any code other than "power-save allowed", holds the mode flag and the run counter cleared.

Top module: `pskip_ctrl`

## Requirements
- R1: With en_mode = 2'b01 and fault low, psave_act rises in the clock cycle after the ENTRY_CNT-th (default 8) consecutive cyc_stb pulse that has zc_seen high, and not earlier.
- R2: Any cyc_stb pulse with zc_seen low clears psave_act in the following clock cycle.
- R3: ls_zc_off (request to turn off the low-side switch at zero crossing) is high exactly while the block is in power-save mode.
- R4: ton_ext (1 = extended on-time, 0 = normal) is high exactly while the block is in power-save mode.
- R5: With en_mode = 2'b10 (forced continuous conduction) psave_act stays low and the run count is held at zero, so a later switch to 2'b01 needs a full fresh run of ENTRY_CNT crossings.
- R6: With en_mode = 2'b00 or 2'b11 (off) drv_hiz is high and psave_act, ls_zc_off and ton_ext are low from the next clock; with 2'b01 or 2'b10 drv_hiz is low.
- R7: A high fault input clears psave_act and the run count on the next clock; a full fresh run is then needed to re-enter.
- R8: A run interrupted by one period without a crossing restarts from zero.
- R9: zc_seen is ignored in clock cycles without cyc_stb: it neither advances nor clears the run, and psave_act does not change.
- R10: Once in power-save mode, further crossing periods keep it there (the count saturates, it does not wrap).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_stb | input | 1 | One-cycle strobe, once per switching period, at end of low-side conduction |
| zc_seen | input | 1 | Zero-crossing comparator fired this period |
| en_mode | input | 2 | 00 off, 01 on with power-save, 10 on forced continuous, 11 off |
| fault | input | 1 | Controller fault; clears power-save state |
| psave_act | output | 1 | Power-save mode active |
| ls_zc_off | output | 1 | Turn low-side switch off at zero crossing |
| ton_ext | output | 1 | Select extended on-time |
| drv_hiz | output | 1 | Float both gate drivers |

## Verification
The bench targets the entry boundary (seven crossings must not enter, the eighth must), which an off-by-one counter would miss by entering a period early or late. It interrupts runs midway and toggles zc_seen between strobes; a counter that failed to clear on a miss, or sampled without the strobe, would enter too soon. It also switches into forced continuous mode, off and fault after a partial run, where a counter left uncleared would let the next run enter early, and keeps crossings coming past the entry count, where a wrapping counter would still be harmless but a flag tied to the count would drop.

// File: rtl/pskip_pkg.sv
package pskip_pkg;
   typedef enum logic [1:0] {
      EN_OFF    = 2'b00,
      EN_PSAVE  = 2'b01,
      EN_CCM    = 2'b10,
      EN_OFF_ALT= 2'b11
   } en_mode_e;
endpackage

// File: rtl/pskip_en_decode.sv
module pskip_en_decode
   import pskip_pkg::*;
(
   input  logic [1:0] en_mode,
   input  logic       fault,
   output logic       ps_allow,
   output logic       drv_float
);
   en_mode_e mode;
   always_comb begin
      mode      = en_mode_e'(en_mode);
      ps_allow  = (mode == EN_PSAVE) && !fault;
      drv_float = (mode == EN_OFF) || (mode == EN_OFF_ALT);
   end
endmodule

// File: rtl/pskip_zc_run.sv
module pskip_zc_run #(
   parameter int ENTRY_CNT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic stb,
   input  logic zc,
   output logic run_done
);
   localparam int CNT_W = (ENTRY_CNT > 1) ? $clog2(ENTRY_CNT) : 1;

   generate
      if (ENTRY_CNT < 1) begin : g_bad_cnt
         $error("ENTRY_CNT must be at least 1");
      end
      if (ENTRY_CNT == 1) begin : g_direct
         assign run_done = stb & zc & ~clr;
      end else begin : g_count
         localparam logic [CNT_W-1:0] LAST = CNT_W'(ENTRY_CNT - 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt_q <= '0;
            else if (clr)        cnt_q <= '0;
            else if (stb) begin
               if (!zc)               cnt_q <= '0;
               else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
            end
         end
         assign run_done = stb & zc & ~clr & (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/pskip_ctrl.sv
module pskip_ctrl #(
   parameter int ENTRY_CNT = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cyc_stb,
   input  logic       zc_seen,
   input  logic [1:0] en_mode,
   input  logic       fault,
   output logic       psave_act,
   output logic       ls_zc_off,
   output logic       ton_ext,
   output logic       drv_hiz
);
   logic ps_allow;
   logic run_done;
   logic mode_q;

   pskip_en_decode u_dec (
      .en_mode  (en_mode),
      .fault    (fault),
      .ps_allow (ps_allow),
      .drv_float(drv_hiz)
   );

   pskip_zc_run #(.ENTRY_CNT(ENTRY_CNT)) u_run (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (~ps_allow),
      .stb     (cyc_stb),
      .zc      (zc_seen),
      .run_done(run_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mode_q <= 1'b0;
      else if (!ps_allow) mode_q <= 1'b0;
      else if (cyc_stb)   mode_q <= zc_seen & (mode_q | run_done);
   end

   assign psave_act = mode_q;
   assign ls_zc_off = mode_q;
   assign ton_ext   = mode_q;
endmodule

// File: rtl/pskip_ctrl_chk.sv
module pskip_ctrl_chk #(
   parameter int ENTRY_CNT = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cyc_stb,
   input logic       zc_seen,
   input logic [1:0] en_mode,
   input logic       fault,
   input logic       psave_act,
   input logic       ls_zc_off,
   input logic       ton_ext,
   input logic       drv_hiz
);
   localparam int RW = $clog2(ENTRY_CNT + 1);
   logic [RW-1:0] run_q;
   logic allow;
   assign allow = (en_mode == 2'b01) && !fault;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     run_q <= '0;
      else if (!allow)                run_q <= '0;
      else if (cyc_stb && !zc_seen)   run_q <= '0;
      else if (cyc_stb && run_q != RW'(ENTRY_CNT)) run_q <= run_q + 1'b1;
   end

   // R1: entry only after a full run of crossing periods
   a_r1_full_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(psave_act) |-> run_q == RW'(ENTRY_CNT));
   a_r2_exit_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_stb && !zc_seen) |=> !psave_act);
   a_r5_ccm_no_psave: assert property (@(posedge clk) disable iff (!rst_n)
      (en_mode == 2'b10) |=> !psave_act);
   a_r6_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (en_mode == 2'b00 || en_mode == 2'b11) |=> (!ls_zc_off && !ton_ext && drv_hiz == (en_mode == 2'b00 || en_mode == 2'b11)));
   a_r7_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !psave_act);
   a_r9_hold_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
      (!cyc_stb && allow) |=> $stable(psave_act));
endmodule

bind pskip_ctrl pskip_ctrl_chk #(.ENTRY_CNT(ENTRY_CNT)) u_chk (.*);

// File: tb/pskip_ctrl_test.sv
module pskip_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_stb = 1'b0;
   logic       zc_seen = 1'b0;
   logic [1:0] en_mode = 2'b01;
   logic       fault = 1'b0;
   logic       psave_act, ls_zc_off, ton_ext, drv_hiz;
   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   pskip_ctrl #(.ENTRY_CNT(8)) uut (
      .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .zc_seen(zc_seen),
      .en_mode(en_mode), .fault(fault), .psave_act(psave_act),
      .ls_zc_off(ls_zc_off), .ton_ext(ton_ext), .drv_hiz(drv_hiz)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // one switching period; outputs settled on return
   task automatic period(input logic z);
      @(negedge clk); cyc_stb = 1'b1; zc_seen = z;
      @(negedge clk); cyc_stb = 1'b0; zc_seen = 1'b0;
   endtask

   task automatic periods(input int n, input logic z);
      for (int i = 0; i < n; i++) period(z);
   endtask

   task automatic chk_mode(input string req, input logic exp);
      chk(req, psave_act, exp);
      chk({req, " ls_zc_off R3"}, ls_zc_off, exp);
      chk({req, " ton_ext R4"}, ton_ext, exp);
   endtask

   task automatic clean_exit();
      period(1'b0);
   endtask

   task automatic t_reset();
      chk_mode("R1 reset", 1'b0);
      chk("R6 drv_hiz enabled", drv_hiz, 1'b0);
   endtask

   task automatic t_entry();
      periods(7, 1'b1);
      chk_mode("R1 seven crossings", 1'b0);
      period(1'b1);
      chk_mode("R1 eighth crossing", 1'b1);
      periods(12, 1'b1);
      chk_mode("R10 saturate", 1'b1);
   endtask

   task automatic t_exit();
      period(1'b0);
      chk_mode("R2 exit on miss", 1'b0);
      periods(7, 1'b1);
      chk_mode("R2 re-entry not early", 1'b0);
      period(1'b1);
      chk_mode("R2 re-entry", 1'b1);
      clean_exit();
   endtask

   task automatic t_interrupt();
      periods(5, 1'b1);
      period(1'b0);
      periods(7, 1'b1);
      chk_mode("R8 interrupted run", 1'b0);
      period(1'b1);
      chk_mode("R8 run after restart", 1'b1);
      clean_exit();
   endtask

   task automatic t_no_stb();
      periods(7, 1'b1);
      repeat (4) begin
         @(negedge clk); zc_seen = 1'b1;
         @(negedge clk); zc_seen = 1'b0;
      end
      chk_mode("R9 no strobe no count", 1'b0);
      period(1'b1);
      chk_mode("R9 no strobe no clear", 1'b1);
      repeat (3) begin @(negedge clk); zc_seen = 1'b0; end
      chk_mode("R9 hold without strobe", 1'b1);
      clean_exit();
   endtask

   task automatic t_ccm();
      periods(4, 1'b1);
      @(negedge clk); en_mode = 2'b10;
      periods(10, 1'b1);
      chk_mode("R5 ccm stays normal", 1'b0);
      chk("R6 ccm drivers active", drv_hiz, 1'b0);
      @(negedge clk); en_mode = 2'b01;
      periods(7, 1'b1);
      chk_mode("R5 fresh run after ccm", 1'b0);
      period(1'b1);
      chk_mode("R5 entry after ccm", 1'b1);
      @(negedge clk); en_mode = 2'b10;
      @(negedge clk);
      chk_mode("R5 ccm forces exit", 1'b0);
      en_mode = 2'b01;
   endtask

   task automatic t_off();
      periods(8, 1'b1);
      chk_mode("R6 entered before off", 1'b1);
      @(negedge clk); en_mode = 2'b00;
      #1 chk("R6 drv_hiz off 00", drv_hiz, 1'b1);
      @(negedge clk);
      chk_mode("R6 off clears", 1'b0);
      en_mode = 2'b11;
      #1 chk("R6 drv_hiz off 11", drv_hiz, 1'b1);
      @(negedge clk); en_mode = 2'b01;
      periods(7, 1'b1);
      chk_mode("R6 fresh run after off", 1'b0);
      period(1'b1);
      chk_mode("R6 entry after off", 1'b1);
   endtask

   task automatic t_fault();
      @(negedge clk); fault = 1'b1;
      @(negedge clk); fault = 1'b0;
      chk_mode("R7 fault clears", 1'b0);
      periods(7, 1'b1);
      chk_mode("R7 fresh run after fault", 1'b0);
      period(1'b1);
      chk_mode("R7 entry after fault", 1'b1);
      clean_exit();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_entry();
      t_exit();
      t_interrupt();
      t_no_stb();
      t_ccm();
      t_off();
      t_fault();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule